// File: doc/BRIEF.md
# Double-Threshold Survivor Pruner

This block chooses which decoding paths survive one expansion step of a list decoder. Each expansion turns `LIST` paths into `2*LIST` candidates. Each candidate carries a path metric, where a lower metric is better, and a record naming its parent path and the bit it appended. The block does not sort the candidates. It classifies every candidate against two thresholds.

- A candidate whose metric is at or below the low threshold is retained.
- A candidate whose metric is at or above the high threshold is dropped.
- Candidates that fall strictly between the two thresholds are taken in candidate-index order. They fill whatever survivor slots remain open.

The block always emits exactly `LIST` survivor records. When fewer than `LIST` candidates qualify, the open slots repeat the lowest-metric candidate. The latency is fixed at two clock cycles whatever the list size. The first cycle classifies and ranks, and the second compacts the survivors into output slots. A new candidate set may be presented on every cycle. Choosing the thresholds, copying the path memory and any final codeword check belong to the surrounding decoder.

Top module: `dtListPruner`

## Requirements
- R1: A candidate whose metric is less than or equal to `thrLow` is always among the survivors whenever at most `LIST` candidates satisfy that condition. Candidate i uses metric bits `[i*METRIC_W +: METRIC_W]`, parent bits `[i*IDX_W +: IDX_W]` and bit value `inBit[i]`.
- R2: A candidate whose metric is greater than or equal to the effective high threshold never occupies a slot, except as the repeated filler of R6.
- R3: Candidates whose metric lies strictly between the low threshold and the effective high threshold fill the open slots in ascending candidate-index order. They stop when all `LIST` slots are used.
- R4: When more than `LIST` candidates are at or below `thrLow`, the survivors are exactly the first `LIST` of them in ascending candidate-index order.
- R5: Slot s holds the s-th selected candidate. Retained candidates come first in index order, followed by middle-band candidates in index order. Slot s appears at `outParent[s*IDX_W +: IDX_W]` and `outBit[s]`.
- R6: When fewer than `LIST` candidates are selected, every remaining slot carries the candidate with the lowest metric of the set, with ties going to the lowest index. This also holds when no candidate is selected at all.
- R7: When `thrLow` is greater than `thrHigh`, the effective high threshold equals `thrLow`. The middle band is then empty, a metric equal to `thrLow` is retained, and any larger metric is dropped.
- R8: `outValid` is high for exactly one cycle, two clock edges after the edge that samples `inValid` high. Sets presented on consecutive cycles produce pulses on consecutive cycles.
- R9: After reset, `outValid` is 0 and all survivor records are 0. The survivor records keep their value in every cycle in which `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Candidate set present this cycle |
| inMetric | input | 2*LIST*METRIC_W | Candidate path metrics, lower is better |
| inParent | input | 2*LIST*IDX_W | Parent path index per candidate |
| inBit | input | 2*LIST | Appended bit value per candidate |
| thrLow | input | METRIC_W | Retain threshold (inclusive) |
| thrHigh | input | METRIC_W | Drop threshold (inclusive) |
| outValid | output | 1 | Survivor records valid pulse |
| outParent | output | LIST*IDX_W | Parent index per survivor slot |
| outBit | output | LIST | Bit value per survivor slot |

## Verification
The checks that run on every cycle cover the following:
- The two-cycle pulse timing.
- Output holding between pulses.
- Retention of candidate 0 whenever its metric is at or below the low threshold.
- The fully retained case, where the slots must mirror the first `LIST` candidates in order.

Only the bench's scenarios can show the behaviours that depend on the whole candidate set. These are the band-fill order, the overflow cut, the filler choice for partly or wholly empty selections, inverted thresholds, and metrics lying exactly on a threshold. The bench compares these against an independent sequential selection model.

// File: rtl/prune_pkg.sv
package prune_pkg;
  typedef struct packed {
    logic loadClass;
    logic loadOut;
  } pruneStrobe_t;
endpackage

// File: rtl/pruneCtrl.sv
module pruneCtrl
  import prune_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output pruneStrobe_t strobe,
  output logic         outValid
);
  logic stageValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      outValid   <= 1'b0;
    end else begin
      stageValid <= inValid;
      outValid   <= stageValid;
    end
  end

  always_comb begin
    strobe.loadClass = inValid;
    strobe.loadOut   = stageValid;
  end
endmodule

// File: rtl/pruneClassify.sv
module pruneClassify #(
  parameter int LIST     = 16,
  parameter int METRIC_W = 12,
  localparam int CAND    = 2 * LIST,
  localparam int CAND_W  = $clog2(CAND),
  localparam int RANK_W  = $clog2(CAND + 1) + 1
) (
  input  logic [CAND*METRIC_W-1:0] metric,
  input  logic [METRIC_W-1:0]      thrLow,
  input  logic [METRIC_W-1:0]      thrHigh,
  output logic [CAND*RANK_W-1:0]   rankFlat,
  output logic [CAND-1:0]          selMask,
  output logic [RANK_W-1:0]        total,
  output logic [CAND_W-1:0]        bestIdx
);
  localparam logic [RANK_W-1:0] LIST_R = RANK_W'(LIST);

  logic [METRIC_W-1:0] thrHighEff;
  logic [CAND-1:0]     isKeep;
  logic [CAND-1:0]     isBand;

  assign thrHighEff = (thrHigh < thrLow) ? thrLow : thrHigh;

  for (genvar i = 0; i < CAND; i++) begin : g_class
    logic [METRIC_W-1:0] m;
    assign m         = metric[i*METRIC_W +: METRIC_W];
    assign isKeep[i] = (m <= thrLow);
    assign isBand[i] = (m > thrLow) && (m < thrHighEff);
  end

  always_comb begin
    logic [RANK_W-1:0] kAcc;
    logic [RANK_W-1:0] bAcc;
    logic [RANK_W-1:0] keepUsed;
    logic [RANK_W-1:0] r;
    logic [RANK_W-1:0] sum;
    kAcc    = '0;
    bAcc    = '0;
    selMask = '0;
    rankFlat = '0;
    for (int i = 0; i < CAND; i++) begin
      if (isKeep[i]) begin
        rankFlat[i*RANK_W +: RANK_W] = kAcc;
        selMask[i] = (kAcc < LIST_R);
      end
      kAcc = kAcc + {{(RANK_W-1){1'b0}}, isKeep[i]};
    end
    keepUsed = (kAcc > LIST_R) ? LIST_R : kAcc;
    for (int i = 0; i < CAND; i++) begin
      r = keepUsed + bAcc;
      if (isBand[i]) begin
        rankFlat[i*RANK_W +: RANK_W] = r;
        selMask[i] = (r < LIST_R);
      end
      bAcc = bAcc + {{(RANK_W-1){1'b0}}, isBand[i]};
    end
    sum   = keepUsed + bAcc;
    total = (sum > LIST_R) ? LIST_R : sum;
  end

  always_comb begin
    logic [METRIC_W-1:0] bestM;
    bestIdx = '0;
    bestM   = metric[METRIC_W-1:0];
    for (int i = 1; i < CAND; i++) begin
      if (metric[i*METRIC_W +: METRIC_W] < bestM) begin
        bestM   = metric[i*METRIC_W +: METRIC_W];
        bestIdx = CAND_W'(i);
      end
    end
  end
endmodule

// File: rtl/pruneCompact.sv
module pruneCompact #(
  parameter int LIST    = 16,
  localparam int CAND   = 2 * LIST,
  localparam int IDX_W  = $clog2(LIST),
  localparam int CAND_W = $clog2(CAND),
  localparam int RANK_W = $clog2(CAND + 1) + 1
) (
  input  logic [CAND*RANK_W-1:0] rankFlat,
  input  logic [CAND-1:0]        selMask,
  input  logic [RANK_W-1:0]      total,
  input  logic [CAND_W-1:0]      bestIdx,
  input  logic [CAND*IDX_W-1:0]  parent,
  input  logic [CAND-1:0]        bitVal,
  output logic [LIST*IDX_W-1:0]  slotParent,
  output logic [LIST-1:0]        slotBit
);
  for (genvar s = 0; s < LIST; s++) begin : g_slot
    localparam logic [RANK_W-1:0] SLOT = RANK_W'(s);
    always_comb begin
      slotParent[s*IDX_W +: IDX_W] = parent[bestIdx*IDX_W +: IDX_W];
      slotBit[s]                   = bitVal[bestIdx];
      if (SLOT < total) begin
        for (int i = 0; i < CAND; i++) begin
          if (selMask[i] && (rankFlat[i*RANK_W +: RANK_W] == SLOT)) begin
            slotParent[s*IDX_W +: IDX_W] = parent[i*IDX_W +: IDX_W];
            slotBit[s]                   = bitVal[i];
          end
        end
      end
    end
  end
endmodule

// File: rtl/pruneDatapath.sv
module pruneDatapath
  import prune_pkg::*;
#(
  parameter int LIST     = 16,
  parameter int METRIC_W = 12,
  localparam int CAND    = 2 * LIST,
  localparam int IDX_W   = $clog2(LIST),
  localparam int CAND_W  = $clog2(CAND),
  localparam int RANK_W  = $clog2(CAND + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pruneStrobe_t             strobe,
  input  logic [CAND*METRIC_W-1:0] inMetric,
  input  logic [CAND*IDX_W-1:0]    inParent,
  input  logic [CAND-1:0]          inBit,
  input  logic [METRIC_W-1:0]      thrLow,
  input  logic [METRIC_W-1:0]      thrHigh,
  output logic [LIST*IDX_W-1:0]    outParent,
  output logic [LIST-1:0]          outBit
);
  logic [CAND*RANK_W-1:0] rankD, rankQ;
  logic [CAND-1:0]        selD, selQ;
  logic [RANK_W-1:0]      totalD, totalQ;
  logic [CAND_W-1:0]      bestD, bestQ;
  logic [CAND*IDX_W-1:0]  parentQ;
  logic [CAND-1:0]        bitQ;
  logic [LIST*IDX_W-1:0]  slotParent;
  logic [LIST-1:0]        slotBit;

  pruneClassify #(.LIST(LIST), .METRIC_W(METRIC_W)) u_class (
    .metric   (inMetric),
    .thrLow   (thrLow),
    .thrHigh  (thrHigh),
    .rankFlat (rankD),
    .selMask  (selD),
    .total    (totalD),
    .bestIdx  (bestD)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rankQ   <= '0;
      selQ    <= '0;
      totalQ  <= '0;
      bestQ   <= '0;
      parentQ <= '0;
      bitQ    <= '0;
    end else if (strobe.loadClass) begin
      rankQ   <= rankD;
      selQ    <= selD;
      totalQ  <= totalD;
      bestQ   <= bestD;
      parentQ <= inParent;
      bitQ    <= inBit;
    end
  end

  pruneCompact #(.LIST(LIST)) u_compact (
    .rankFlat   (rankQ),
    .selMask    (selQ),
    .total      (totalQ),
    .bestIdx    (bestQ),
    .parent     (parentQ),
    .bitVal     (bitQ),
    .slotParent (slotParent),
    .slotBit    (slotBit)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outParent <= '0;
      outBit    <= '0;
    end else if (strobe.loadOut) begin
      outParent <= slotParent;
      outBit    <= slotBit;
    end
  end
endmodule

// File: rtl/dtListPruner.sv
module dtListPruner
  import prune_pkg::*;
#(
  parameter int LIST     = 16,
  parameter int METRIC_W = 12,
  localparam int CAND    = 2 * LIST,
  localparam int IDX_W   = $clog2(LIST)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [CAND*METRIC_W-1:0] inMetric,
  input  logic [CAND*IDX_W-1:0]    inParent,
  input  logic [CAND-1:0]          inBit,
  input  logic [METRIC_W-1:0]      thrLow,
  input  logic [METRIC_W-1:0]      thrHigh,
  output logic                     outValid,
  output logic [LIST*IDX_W-1:0]    outParent,
  output logic [LIST-1:0]          outBit
);
  pruneStrobe_t strobe;

  pruneCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  pruneDatapath #(.LIST(LIST), .METRIC_W(METRIC_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inMetric  (inMetric),
    .inParent  (inParent),
    .inBit     (inBit),
    .thrLow    (thrLow),
    .thrHigh   (thrHigh),
    .outParent (outParent),
    .outBit    (outBit)
  );
endmodule

// File: rtl/pruneChecker.sv
module pruneChecker #(
  parameter int LIST     = 16,
  parameter int METRIC_W = 12,
  localparam int CAND    = 2 * LIST,
  localparam int IDX_W   = $clog2(LIST)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic [CAND*METRIC_W-1:0] inMetric,
  input logic [CAND*IDX_W-1:0]    inParent,
  input logic [CAND-1:0]          inBit,
  input logic [METRIC_W-1:0]      thrLow,
  input logic                     outValid,
  input logic [LIST*IDX_W-1:0]    outParent,
  input logic [LIST-1:0]          outBit
);
  logic [1:0] sinceReset;
  logic       allLow;

  always_ff @(posedge clk) begin
    if (!rstN) sinceReset <= '0;
    else if (sinceReset != 2'd3) sinceReset <= sinceReset + 2'd1;
  end

  always_comb begin
    allLow = 1'b1;
    for (int i = 0; i < CAND; i++)
      if (inMetric[i*METRIC_W +: METRIC_W] > thrLow) allLow = 1'b0;
  end

  // R8: a sampled set yields a pulse two edges later
  a_r8_pulse_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##1 outValid);

  // R8: no pulse without a set two edges earlier
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && sinceReset >= 2'd2) |-> $past(inValid, 2));

  // R9: records hold while no pulse is shown
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid && sinceReset >= 2'd1) |-> ($stable(outParent) && $stable(outBit)));

  // R1: candidate 0 at or below the low threshold lands in slot 0
  a_r1_first_kept: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && sinceReset >= 2'd2 && $past(inMetric[METRIC_W-1:0] <= thrLow, 2))
      |-> (outParent[IDX_W-1:0] == $past(inParent[IDX_W-1:0], 2)
           && outBit[0] == $past(inBit[0], 2)));

  // R4: all candidates retained means the first LIST fill the slots in order
  a_r4_overflow_cut: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && sinceReset >= 2'd2 && $past(allLow, 2))
      |-> (outParent == $past(inParent[LIST*IDX_W-1:0], 2)
           && outBit == $past(inBit[LIST-1:0], 2)));
endmodule

bind dtListPruner pruneChecker #(.LIST(LIST), .METRIC_W(METRIC_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inMetric  (inMetric),
  .inParent  (inParent),
  .inBit     (inBit),
  .thrLow    (thrLow),
  .outValid  (outValid),
  .outParent (outParent),
  .outBit    (outBit)
);

// File: tb/tb_dtListPruner.sv
module tb_dtListPruner;
  localparam int LIST = 16;
  localparam int MW   = 12;
  localparam int CAND = 2 * LIST;
  localparam int IW   = $clog2(LIST);

  // seed, step, thrLow, thrHigh; metric i = (seed + i*step) mod 4096
  localparam int NVEC = 8;
  localparam int VEC [NVEC][4] = '{
    '{100,  53,  600, 1200},  // R1 R2 R3 R5 mixed classes
    '{5,    3,   2000, 3000}, // R4 every candidate retained
    '{1000, 97,  10,  1500},  // R3 R6 band only, partial fill
    '{2000, 1,   100, 200},   // R6 R2 nothing selected
    '{0,    61,  900, 300},   // R7 inverted thresholds
    '{500,  0,   400, 600},   // R3 ties, all in band
    '{4000, 131, 1000, 2500}, // R5 wrapping metrics
    '{300,  100, 500, 1000}   // R1 R2 metrics on thresholds
  };

  logic                 clk = 0;
  logic                 rstN;
  logic                 inValid;
  logic [CAND*MW-1:0]   inMetric;
  logic [CAND*IW-1:0]   inParent;
  logic [CAND-1:0]      inBit;
  logic [MW-1:0]        thrLow, thrHigh;
  logic                 outValid;
  logic [LIST*IW-1:0]   outParent;
  logic [LIST-1:0]      outBit;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dtListPruner #(.LIST(LIST), .METRIC_W(MW)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inMetric(inMetric),
    .inParent(inParent), .inBit(inBit), .thrLow(thrLow), .thrHigh(thrHigh),
    .outValid(outValid), .outParent(outParent), .outBit(outBit)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadSet(input int seed, input int step, input int lo, input int hi);
    for (int i = 0; i < CAND; i++) begin
      inMetric[i*MW +: MW] = MW'((seed + i * step) % 4096);
      inParent[i*IW +: IW] = IW'(i >> 1);
      inBit[i]             = i[0];
    end
    thrLow  = MW'(lo);
    thrHigh = MW'(hi);
  endtask

  // sequential selection model built from R1-style rules
  task automatic model(output logic [LIST*IW-1:0] eP, output logic [LIST-1:0] eB);
    int cnt = 0;
    int best = 0;
    int hiEff;
    hiEff = (thrHigh < thrLow) ? int'(thrLow) : int'(thrHigh);
    eP = '0;
    eB = '0;
    for (int i = 0; i < CAND; i++)
      if (int'(inMetric[i*MW +: MW]) <= int'(thrLow) && cnt < LIST) begin
        eP[cnt*IW +: IW] = inParent[i*IW +: IW]; eB[cnt] = inBit[i]; cnt++;
      end
    for (int i = 0; i < CAND; i++) begin
      int m;
      m = int'(inMetric[i*MW +: MW]);
      if (m > int'(thrLow) && m < hiEff && cnt < LIST) begin
        eP[cnt*IW +: IW] = inParent[i*IW +: IW]; eB[cnt] = inBit[i]; cnt++;
      end
    end
    for (int i = 1; i < CAND; i++)
      if (inMetric[i*MW +: MW] < inMetric[best*MW +: MW]) best = i;
    for (int s = cnt; s < LIST; s++) begin
      eP[s*IW +: IW] = inParent[best*IW +: IW]; eB[s] = inBit[best];
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nBad++;
      nChk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin : stim
    logic [LIST*IW-1:0] eP, eP2, holdP;
    logic [LIST-1:0]    eB, eB2, holdB;
    rstN = 0; inValid = 0;
    loadSet(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R9 reset valid", 64'(outValid), 64'd0);
    chk("R9 reset records", 64'(outParent), 64'd0);
    chk("R9 reset bits", 64'(outBit), 64'd0);
    rstN = 1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      loadSet(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      model(eP, eB);
      inValid = 1;
      @(negedge clk);
      inValid = 0;
      chk("R8 no early pulse", 64'(outValid), 64'd0);
      @(negedge clk);
      chk("R8 pulse", 64'(outValid), 64'd1);
      chk($sformatf("R1-R7 parents vec %0d", v), 64'(outParent), 64'(eP));
      chk($sformatf("R5 bits vec %0d", v), 64'(outBit), 64'(eB));
      @(negedge clk);
      chk("R8 single pulse", 64'(outValid), 64'd0);
    end

    // R9: outputs hold while idle inputs change
    holdP = outParent; holdB = outBit;
    loadSet(7, 11, 4000, 4095);
    repeat (3) @(negedge clk);
    chk("R9 hold records", 64'(outParent), 64'(holdP));
    chk("R9 hold bits", 64'(outBit), 64'(holdB));
    chk("R9 no pulse", 64'(outValid), 64'd0);

    // R8: back-to-back sets
    loadSet(100, 53, 600, 1200); model(eP, eB); inValid = 1;
    @(negedge clk);
    loadSet(2000, 1, 100, 200); model(eP2, eB2);
    @(negedge clk);
    inValid = 0;
    chk("R8 b2b first pulse", 64'(outValid), 64'd1);
    chk("R8 b2b first records", 64'(outParent), 64'(eP));
    @(negedge clk);
    chk("R8 b2b second pulse", 64'(outValid), 64'd1);
    chk("R6 b2b second records", 64'(outParent), 64'(eP2));
    chk("R6 b2b second bits", 64'(outBit), 64'(eB2));

    // R2 R6: only candidate 9 is selected; every other candidate is at the drop threshold
    loadSet(3000, 0, 100, 3000);
    inMetric[9*MW +: MW] = MW'(50);
    inValid = 1;
    @(negedge clk);
    inValid = 0;
    @(negedge clk);
    chk("R2 R6 lone survivor fills", 64'(outParent), {48'd0, {LIST{4'(9 >> 1)}}});
    chk("R6 lone survivor bit", 64'(outBit), 64'({LIST{1'b1}}));

    @(negedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule